// File: doc/BRIEF.md
# Grouped Interrupt Flag Controller

This block gathers the event signals of two acquisition groups of a fast parallel digital capture engine into per-group flag registers, masks them with per-group enable registers, and raises one interrupt request on a selectable line. A byte-wide register port gives access to the flags, the enables, two clear registers per group, a per-group transfer counter, a window-address register and a master control register. A status register shows which groups have an enabled flag pending.

Each group has one level flag and four sticky flags. The level flag is word-ready, which follows the FIFO-not-empty input. The sticky flags are count-expired, waited, primary terminal count and secondary terminal count. Three of the sticky flags are cleared through a first clear register. That register also issues DMA and FIFO reset pulses. Count-expired can be cleared only through a second clear register.

The transfer counter is a three-state machine: IDLE (disarmed), RUN (counting samples down) and DONE (expired, waiting for a new arm). A write to the counter's top byte arms it. The transition IDLE/DONE→RUN happens on an arm with a nonzero count, and any state→IDLE on an arm with zero. The transition RUN→DONE happens on the sample that exhausts the count, and that same sample sets count-expired.

The interrupt output is a second three-state machine: OFF (line field zero), QUIET (line selected, nothing pending) and RAISED (line selected, something pending). It is re-evaluated every cycle, so the request follows the pending state one cycle later.

Top module: `grpirq_top`

Register map (4-bit address, g = group 0 or 1):

| Address | Write | Read |
|---|---|---|
| 0x0 | window address (bits 4:0) | status |
| 0x1 | master control | master control |
| 0x2+g | clear register A | flags |
| 0x4+g | clear register B | 0 |
| 0x6+g | enable | enable |
| 0x8+4g .. 0xB+4g | count, least significant byte first; a write to the top byte arms the counter | count bytes |

## Requirements
- R1: Flag bit 0 (word-ready) equals the FIFO-not-empty input as sampled at the previous clock edge. No clear write changes it.
- R2: Flag bits 5 (waited), 6 (primary terminal count) and 7 (secondary terminal count) are set by a one-cycle event pulse and stay set until cleared. Flag bits 4:2 always read 0.
- R3: Writing clear register A clears flags by bit position: data bit 3 clears waited, bit 4 clears primary terminal count and bit 5 clears secondary terminal count. Writing 0xF8 clears all three.
- R4: In the cycle after a clear register A write, data bit 6 yields a one-cycle pulse on that group's dma_rst_o bit and data bit 7 yields one on its fifo_rst_o bit.
- R5: Flag bit 1 (count-expired) is unaffected by any clear register A write. Writing clear register B with data bit 0 set clears it.
- R6: If an event pulse and a clear write for the same flag land in the same cycle, the flag is set afterwards.
- R7: The transfer count is written as four bytes, least significant byte first, and a write to the top byte arms the counter. The sample pulse that completes N samples sets count-expired. Further samples are ignored until the counter is re-armed. An armed count of 0 never expires. The count bytes read back as written.
- R8: The enable register has the flag layout and reads back as written. A group is pending when any flag bit ANDed with its enable bit is 1. Status bit 0 shows group 0 pending and status bit 1 shows group 1 pending.
- R9: Status bits 6:2 read back the 5-bit window address last written to address 0x0. Status bit 7 reads 0.
- R10: Master control bits 1:0 select the line: value n from 1 to 3 drives irq_line_o bit n-1 one cycle after any group becomes pending. Bit 2 drives irq_od_o. The request drops one cycle after the last pending flag clears.
- R11: When master control bits 1:0 are 0 (for example after writing 0x00), irq_line_o stays 0 while the status pending bits still report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| fifo_nempty_i | input | 2 | Per-group FIFO-not-empty level |
| sample_i | input | 2 | Per-group transferred-sample pulse |
| waited_i | input | 2 | Per-group waited/overrun event pulse |
| ptc_i | input | 2 | Per-group primary terminal count pulse |
| stc_i | input | 2 | Per-group secondary terminal count pulse |
| irq_line_o | output | 3 | Interrupt request, one bit per selectable line |
| irq_od_o | output | 1 | Open-drain drive select |
| dma_rst_o | output | 2 | Per-group DMA reset pulse |
| fifo_rst_o | output | 2 | Per-group FIFO reset pulse |

## Verification
Two functions can fall in the same cycle: a flag's set event and a register write that clears the same flag. The bench provokes this by driving a waited pulse in the same cycle as a clear register A write with data bit 3. It also writes clear register B in the cycle where the final sample of an armed count arrives. In both cases the flag register is read in the following cycle, and the flag is judged correct only if it is still 1.

// File: rtl/grpirq_pkg.sv
package grpirq_pkg;
    localparam int NUM_GRP = 2;
    localparam int ADDR_W  = 4;
    localparam int WIN_W   = 5;

    localparam logic [ADDR_W-1:0] A_STATUS    = 4'h0;
    localparam logic [ADDR_W-1:0] A_MCTL      = 4'h1;
    localparam logic [ADDR_W-1:0] A_FLAG_BASE = 4'h2;
    localparam logic [ADDR_W-1:0] A_CLRB_BASE = 4'h4;
    localparam logic [ADDR_W-1:0] A_EN_BASE   = 4'h6;
    localparam logic [ADDR_W-1:0] A_CNT_BASE  = 4'h8;
    localparam int CNT_SLOTS = 4;

    // flag bit positions (decoded by software, so fixed)
    localparam int B_RDY  = 0;
    localparam int B_EXP  = 1;
    localparam int B_WAIT = 5;
    localparam int B_PTC  = 6;
    localparam int B_STC  = 7;

    // clear register A / B bit positions
    localparam int C_WAIT = 3;
    localparam int C_PTC  = 4;
    localparam int C_STC  = 5;
    localparam int C_DMA  = 6;
    localparam int C_FIFO = 7;
    localparam int C_EXP  = 0;

    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_DONE = 2'd2
    } cnt_state_e;

    typedef enum logic [1:0] {
        IRQ_OFF    = 2'd0,
        IRQ_QUIET  = 2'd1,
        IRQ_RAISED = 2'd2
    } irq_state_e;
endpackage

// File: rtl/grpirq_counter.sv
module grpirq_counter
    import grpirq_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W/8-1:0]    byte_we_i,
    input  logic [7:0]            wdata_i,
    input  logic                  sample_i,
    output logic                  expire_o,
    output logic [CNT_W-1:0]      shadow_o
);
    localparam int NBYTES = CNT_W / 8;

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] load_val;
    logic             arm;

    assign arm      = byte_we_i[NBYTES-1];
    assign load_val = {wdata_i, shadow_o[CNT_W-9:0]};

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow_o[8*i +: 8] <= '0;
            else if (byte_we_i[i])
                shadow_o[8*i +: 8] <= wdata_i;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CNT_IDLE;
            remain_q <= '0;
        end else begin
            state_q <= state_d;
            if (arm)
                remain_q <= load_val;
            else if (state_q == CNT_RUN && sample_i)
                remain_q <= remain_q - CNT_W'(1);
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        expire_o = 1'b0;
        if (arm) begin
            state_d = (load_val != '0) ? CNT_RUN : CNT_IDLE;
        end else begin
            unique case (state_q)
                CNT_IDLE: state_d = CNT_IDLE;
                CNT_RUN: begin
                    if (sample_i && remain_q == CNT_W'(1)) begin
                        state_d  = CNT_DONE;
                        expire_o = 1'b1;
                    end
                end
                CNT_DONE: state_d = CNT_DONE;
                default:  state_d = CNT_IDLE;
            endcase
        end
    end

    // R7
    run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == CNT_RUN |-> remain_q != '0);

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_DONE && !arm) |=> state_q == CNT_DONE);
endmodule

// File: rtl/grpirq_flags.sv
module grpirq_flags
    import grpirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_nempty_i,
    input  logic       waited_ev_i,
    input  logic       ptc_ev_i,
    input  logic       stc_ev_i,
    input  logic       expire_ev_i,
    input  logic       clra_we_i,
    input  logic       clrb_we_i,
    input  logic       en_we_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] flags_o,
    output logic [7:0] enable_o,
    output logic       pending_o,
    output logic       dma_rst_o,
    output logic       fifo_rst_o
);
    logic rdy_q, exp_q, wait_q, ptc_q, stc_q;
    logic clr_wait, clr_ptc, clr_stc, clr_exp;

    assign clr_wait = clra_we_i && wdata_i[C_WAIT];
    assign clr_ptc  = clra_we_i && wdata_i[C_PTC];
    assign clr_stc  = clra_we_i && wdata_i[C_STC];
    assign clr_exp  = clrb_we_i && wdata_i[C_EXP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q      <= 1'b0;
            exp_q      <= 1'b0;
            wait_q     <= 1'b0;
            ptc_q      <= 1'b0;
            stc_q      <= 1'b0;
            enable_o   <= '0;
            dma_rst_o  <= 1'b0;
            fifo_rst_o <= 1'b0;
        end else begin
            rdy_q      <= fifo_nempty_i;
            exp_q      <= expire_ev_i | (exp_q  & ~clr_exp);
            wait_q     <= waited_ev_i | (wait_q & ~clr_wait);
            ptc_q      <= ptc_ev_i    | (ptc_q  & ~clr_ptc);
            stc_q      <= stc_ev_i    | (stc_q  & ~clr_stc);
            dma_rst_o  <= clra_we_i && wdata_i[C_DMA];
            fifo_rst_o <= clra_we_i && wdata_i[C_FIFO];
            if (en_we_i)
                enable_o <= wdata_i;
        end
    end

    always_comb begin
        flags_o         = '0;
        flags_o[B_RDY]  = rdy_q;
        flags_o[B_EXP]  = exp_q;
        flags_o[B_WAIT] = wait_q;
        flags_o[B_PTC]  = ptc_q;
        flags_o[B_STC]  = stc_q;
    end

    assign pending_o = |(flags_o & enable_o);

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && !clr_wait) |=> wait_q);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        waited_ev_i |=> wait_q);

    // R5
    exp_clra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_q && !clrb_we_i) |=> exp_q);

    // R4
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rst_o |-> $past(clra_we_i && wdata_i[C_DMA]));
endmodule

// File: rtl/grpirq_master.sv
module grpirq_master
    import grpirq_pkg::*;
#(
    parameter int LINE_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctl_we_i,
    input  logic [7:0]                wdata_i,
    input  logic                      pending_i,
    output logic [7:0]                ctl_o,
    output logic [(1<<LINE_W)-2:0]    irq_line_o,
    output logic                      irq_od_o
);
    localparam int NLINES = (1 << LINE_W) - 1;

    irq_state_e        state_q, state_d;
    logic [LINE_W-1:0] line_sel;

    assign line_sel = ctl_o[LINE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_o <= '0;
        else if (ctl_we_i)
            ctl_o <= wdata_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_OFF, IRQ_QUIET, IRQ_RAISED: begin
                if (line_sel == '0)
                    state_d = IRQ_OFF;
                else if (pending_i)
                    state_d = IRQ_RAISED;
                else
                    state_d = IRQ_QUIET;
            end
            default: state_d = IRQ_OFF;
        endcase
    end

    // outputs
    always_comb begin
        for (int i = 0; i < NLINES; i++)
            irq_line_o[i] = (state_q == IRQ_RAISED) && (line_sel == LINE_W'(i + 1));
        irq_od_o = ctl_o[LINE_W];
    end

    // R11
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sel == '0) |=> irq_line_o == '0);

    // R10
    onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_line_o));

    // R10
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> irq_line_o == '0);
endmodule

// File: rtl/grpirq_top.sv
module grpirq_top
    import grpirq_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int LINE_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [NUM_GRP-1:0]      fifo_nempty_i,
    input  logic [NUM_GRP-1:0]      sample_i,
    input  logic [NUM_GRP-1:0]      waited_i,
    input  logic [NUM_GRP-1:0]      ptc_i,
    input  logic [NUM_GRP-1:0]      stc_i,
    output logic [(1<<LINE_W)-2:0]  irq_line_o,
    output logic                    irq_od_o,
    output logic [NUM_GRP-1:0]      dma_rst_o,
    output logic [NUM_GRP-1:0]      fifo_rst_o
);
    localparam int NBYTES = CNT_W / 8;

    logic [WIN_W-1:0]   win_q;
    logic [7:0]         ctl;
    logic [7:0]         flags  [NUM_GRP];
    logic [7:0]         enable [NUM_GRP];
    logic [CNT_W-1:0]   shadow [NUM_GRP];
    logic [NUM_GRP-1:0] pending;
    logic [NUM_GRP-1:0] expire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            win_q <= '0;
        else if (bus_we && bus_addr == A_STATUS)
            win_q <= bus_wdata[WIN_W-1:0];
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [NBYTES-1:0] cnt_we;
        for (genvar i = 0; i < NBYTES; i++) begin : g_we
            assign cnt_we[i] = bus_we &&
                (bus_addr == A_CNT_BASE + ADDR_W'(g * CNT_SLOTS + i));
        end

        grpirq_counter #(.CNT_W(CNT_W)) cnt_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .byte_we_i (cnt_we),
            .wdata_i   (bus_wdata),
            .sample_i  (sample_i[g]),
            .expire_o  (expire[g]),
            .shadow_o  (shadow[g])
        );

        grpirq_flags flg_i (
            .clk           (clk),
            .rst_n         (rst_n),
            .fifo_nempty_i (fifo_nempty_i[g]),
            .waited_ev_i   (waited_i[g]),
            .ptc_ev_i      (ptc_i[g]),
            .stc_ev_i      (stc_i[g]),
            .expire_ev_i   (expire[g]),
            .clra_we_i     (bus_we && bus_addr == A_FLAG_BASE + ADDR_W'(g)),
            .clrb_we_i     (bus_we && bus_addr == A_CLRB_BASE + ADDR_W'(g)),
            .en_we_i       (bus_we && bus_addr == A_EN_BASE + ADDR_W'(g)),
            .wdata_i       (bus_wdata),
            .flags_o       (flags[g]),
            .enable_o      (enable[g]),
            .pending_o     (pending[g]),
            .dma_rst_o     (dma_rst_o[g]),
            .fifo_rst_o    (fifo_rst_o[g])
        );
    end

    grpirq_master #(.LINE_W(LINE_W)) mst_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we_i   (bus_we && bus_addr == A_MCTL),
        .wdata_i    (bus_wdata),
        .pending_i  (|pending),
        .ctl_o      (ctl),
        .irq_line_o (irq_line_o),
        .irq_od_o   (irq_od_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STATUS)
            bus_rdata = {1'b0, win_q, pending[1], pending[0]};
        if (bus_addr == A_MCTL)
            bus_rdata = ctl;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (bus_addr == A_FLAG_BASE + ADDR_W'(g))
                bus_rdata = flags[g];
            if (bus_addr == A_EN_BASE + ADDR_W'(g))
                bus_rdata = enable[g];
            for (int i = 0; i < NBYTES; i++)
                if (bus_addr == A_CNT_BASE + ADDR_W'(g * CNT_SLOTS + i))
                    bus_rdata = shadow[g][8*i +: 8];
        end
    end
endmodule

// File: tb/grpirq_top_tb.sv
`timescale 1ns/1ps
module grpirq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] fifo_nempty = '0, sample = '0, waited = '0, ptc = '0, stc = '0;
    logic [2:0] irq_line;
    logic       irq_od;
    logic [1:0] dma_rst, fifo_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int       kind;
        logic [7:0] exp;
        string    req;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    grpirq_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_nempty_i(fifo_nempty), .sample_i(sample), .waited_i(waited),
        .ptc_i(ptc), .stc_i(stc), .irq_line_o(irq_line), .irq_od_o(irq_od),
        .dma_rst_o(dma_rst), .fifo_rst_o(fifo_rst)
    );

    // monitor: pops expectations and compares them away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = {5'b0, irq_line};
                    2: act = {7'b0, irq_od};
                    3: act = {6'b0, dma_rst};
                    default: act = {6'b0, fifo_rst};
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        bus_we = 1'b0; sample = '0; waited = '0; ptc = '0; stc = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic push(input int kind, input logic [7:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        cyc(); bus_addr = a; push(0, exp, req);
    endtask

    task automatic chk_irq(input logic [7:0] exp, input string req);
        cyc(); push(1, exp, req);
    endtask

    task automatic samples(input int n);
        for (int k = 0; k < n; k++) begin
            cyc(); sample[0] = 1'b1;
        end
    endtask

    task automatic arm0(input logic [31:0] n);
        wr(4'h8, n[7:0]); wr(4'h9, n[15:8]); wr(4'hA, n[23:16]); wr(4'hB, n[31:24]);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        chk(4'h2, 8'h00, "R1"); push(1, 8'h00, "R10");
        chk(4'h0, 8'h00, "R9");

        // R1 word-ready level
        cyc(); fifo_nempty[0] = 1'b1;
        chk(4'h2, 8'h01, "R1");
        wr(4'h2, 8'hFF);
        chk(4'h2, 8'h01, "R1 not clearable");
        cyc(); fifo_nempty[0] = 1'b0;
        chk(4'h2, 8'h00, "R1");

        // R2 sticky flags
        cyc(); waited[0] = 1'b1;
        chk(4'h2, 8'h20, "R2");
        chk(4'h2, 8'h20, "R2 hold");
        cyc(); ptc[0] = 1'b1;
        cyc(); stc[0] = 1'b1;
        chk(4'h2, 8'hE0, "R2");

        // R3 selective clears
        wr(4'h2, 8'h08); chk(4'h2, 8'hC0, "R3 waited");
        wr(4'h2, 8'h10); chk(4'h2, 8'h80, "R3 ptc");
        wr(4'h2, 8'h20); chk(4'h2, 8'h00, "R3 stc");
        cyc(); waited[0] = 1'b1; ptc[0] = 1'b1; stc[0] = 1'b1;
        wr(4'h2, 8'hF8);
        chk(4'h2, 8'h00, "R3 all"); push(3, 8'h01, "R4 dma"); push(4, 8'h01, "R4 fifo");
        cyc(); push(3, 8'h00, "R4 dma end"); push(4, 8'h00, "R4 fifo end");
        wr(4'h2, 8'h40);
        cyc(); push(3, 8'h01, "R4 dma only"); push(4, 8'h00, "R4 dma only");
        wr(4'h3, 8'h80);
        cyc(); push(4, 8'h02, "R4 group1"); push(3, 8'h00, "R4 group1");

        // R7 counter / R5 clears
        arm0(32'd3);
        samples(2);
        chk(4'h2, 8'h00, "R7 before count");
        samples(1);
        chk(4'h2, 8'h02, "R7 expired");
        wr(4'h2, 8'hFF);
        chk(4'h2, 8'h02, "R5 clear A ignored");
        wr(4'h4, 8'h01);
        chk(4'h2, 8'h00, "R5 clear B");
        samples(2);
        chk(4'h2, 8'h00, "R7 extra samples ignored");
        chk(4'h8, 8'h03, "R7 readback");
        arm0(32'd0);
        samples(3);
        chk(4'h2, 8'h00, "R7 zero count");
        arm0(32'h0000_0102);
        samples(257);
        chk(4'h2, 8'h00, "R7 258 before");
        samples(1);
        chk(4'h2, 8'h02, "R7 258 expired");
        chk(4'h9, 8'h01, "R7 readback hi");
        wr(4'h4, 8'h01);

        // R6 same-cycle set and clear
        wr(4'h2, 8'h08); waited[0] = 1'b1;
        chk(4'h2, 8'h20, "R6 waited");
        wr(4'h2, 8'h08);
        arm0(32'd1);
        wr(4'h4, 8'h01); sample[0] = 1'b1;
        chk(4'h2, 8'h02, "R6 expired");
        wr(4'h4, 8'h01);
        chk(4'h2, 8'h00, "R5 clear B again");

        // R8 enables and pending
        wr(4'h6, 8'h20);
        cyc(); ptc[0] = 1'b1;
        chk(4'h0, 8'h00, "R8 masked");
        cyc(); waited[0] = 1'b1;
        chk(4'h0, 8'h01, "R8 group0");
        wr(4'h7, 8'h80);
        cyc(); stc[1] = 1'b1;
        chk(4'h0, 8'h03, "R8 both");
        chk(4'h6, 8'h20, "R8 readback");

        // R9 window
        wr(4'h0, 8'h15);
        chk(4'h0, 8'h57, "R9");
        wr(4'h0, 8'hFF);
        chk(4'h0, 8'h7F, "R9 bit7");

        // R10/R11 master
        chk_irq(8'h00, "R11 disabled");
        wr(4'h1, 8'h02);
        cyc();
        chk_irq(8'h02, "R10 line1"); push(2, 8'h00, "R10 od");
        wr(4'h1, 8'h07);
        cyc();
        chk_irq(8'h04, "R10 line3"); push(2, 8'h01, "R10 od");
        chk(4'h1, 8'h07, "R10 readback");
        wr(4'h2, 8'hF8);
        chk_irq(8'h04, "R10 group1 still");
        wr(4'h3, 8'h20);
        chk_irq(8'h04, "R10 one cycle late");
        chk_irq(8'h00, "R10 dropped");
        wr(4'h6, 8'h21);
        cyc(); fifo_nempty[0] = 1'b1;
        cyc();
        chk_irq(8'h04, "R10 R1 ready irq");
        wr(4'h1, 8'h00);
        cyc();
        chk_irq(8'h00, "R11 off"); bus_addr = 4'h0; push(0, 8'h7D, "R11 pending shown");

        repeat (3) cyc();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule